// File: doc/BRIEF.md
# Selectable Set Replacement Controller

This block picks the way to overwrite inside one set of an N-way associative cache. It keeps a valid bit per way, a recency order, an insertion order and a pseudo-random generator. A `mode_i` input selects which of the three drives the victim choice: least-recently-used, first-in-first-out or random. The cache around it owns the tags, the data and the miss path. It reports each lookup result through `lookup_i`, `hit_i` and `hit_way_i`. When it installs a line it raises `fill_i`, and the line goes into the way shown on `victim_o` in that same cycle.

While a way is still empty, the fill goes to the lowest-numbered empty way, whatever the mode. Once all ways are valid, the selected policy names the victim. Fills update both orders in every mode. Hits reorder the recency order only while the least-recently-used policy is selected. The insertion order and the random generator ignore hits entirely.

Top module: `set_victim_sel`

## Requirements
- R1: After reset, `valid_o` is all zero, `full_o` is 0 and `victim_o` is 0.
- R2: While `full_o` is 0, `victim_o` is the lowest-numbered way whose valid bit is 0. A fill makes that way valid one cycle later, and `full_o` rises once every way is valid.
- R3: In mode 0 (least-recently-used), a hit makes the hit way the most recent, and each way that was more recent moves one step older. A lookup with `hit_i` = 0 changes nothing. With a full set, `victim_o` is the way touched longest ago, whether it was last hit or last filled.
- R4: With 3 ways in mode 0, the tag trace 1 2 3 1 4 2 5 1 gives 1 hit and evicts tags 2, 3, 1, 4 in that order. The trace 1 2 3 1 4 1 gives 2 hits.
- R5: In mode 1 (first-in-first-out), a hit does not change `victim_o`. With a full set, the victim is the way filled earliest, even if it has just been hit.
- R6: With 3 ways in mode 1, the trace 1 2 3 1 4 2 5 1 gives 2 hits and the trace 1 2 3 1 4 1 gives 1 hit.
- R7: In mode 1, the trace 1 2 3 4 1 2 5 1 2 3 4 5 gives 9 misses with 3 ways and 10 misses with 4 ways.
- R8: In mode 2 (random), a hit does not change `victim_o`, and `victim_o` is always below the way count. The generator advances once per fill.
- R9: In mode 2 with 4 ways and an 8-bit generator, the victims shown before 255 consecutive fills into a full set fall 63 times on way 0 and 64 times on each of ways 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode_i | input | 2 | Policy: 0 least-recently-used, 1 first-in-first-out, 2 random (3 acts as 0) |
| lookup_i | input | 1 | A lookup result is presented this cycle |
| hit_i | input | 1 | The lookup hit |
| hit_way_i | input | IDXW | Way that hit |
| fill_i | input | 1 | A line is installed into `victim_o` this cycle |
| victim_o | output | IDXW | Way to fill next |
| valid_o | output | WAYS | Per-way valid bits |
| full_o | output | 1 | All ways valid |

## Verification
The assertions assume the cache only reports hits on valid ways and never presents a hit and a fill in the same cycle. The stability checks also hold only while `mode_i` is unchanged from one cycle to the next. The bench keeps its own tag copy for each way. It raises a hit only for a tag it finds among valid ways and drives a fill only in the cycle after a miss lookup. It changes the mode only while no lookup or fill is active. The expected hit counts, eviction order and way distribution all come from the stated traces and from simple arithmetic on the generator period.

// File: rtl/svs_pkg.sv
package svs_pkg;

  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_RAND = 2'd2,
    POL_RSVD = 2'd3
  } policy_e;

  // Feedback masks for maximal-length shift generators, width 3..16
  function automatic logic [15:0] lfsr_taps(input int width);
    case (width)
      3:       lfsr_taps = 16'h0006;
      4:       lfsr_taps = 16'h000C;
      5:       lfsr_taps = 16'h0014;
      6:       lfsr_taps = 16'h0030;
      7:       lfsr_taps = 16'h0060;
      8:       lfsr_taps = 16'h00B8;
      9:       lfsr_taps = 16'h0110;
      10:      lfsr_taps = 16'h0240;
      11:      lfsr_taps = 16'h0500;
      12:      lfsr_taps = 16'h0829;
      13:      lfsr_taps = 16'h100D;
      14:      lfsr_taps = 16'h2015;
      15:      lfsr_taps = 16'h6000;
      default: lfsr_taps = 16'hD008;
    endcase
  endfunction

endpackage

// File: rtl/svs_order.sv
module svs_order #(
  parameter int WAYS = 4,
  parameter int IDXW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_i,
  input  logic [IDXW-1:0]           way_i,
  output logic [WAYS-1:0][IDXW-1:0] rank_o,
  output logic [IDXW-1:0]           tail_o
);

  logic [WAYS-1:0][IDXW-1:0] rank_q, rank_d;
  logic [IDXW-1:0]           sel_rank;

  // Next state: the chosen way moves to rank 0, younger ones age by one
  always_comb begin
    rank_d   = rank_q;
    sel_rank = rank_q[way_i];
    if (upd_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (IDXW'(w) == way_i)
          rank_d[w] = '0;
        else if (rank_q[w] < sel_rank)
          rank_d[w] = rank_q[w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) rank_q[w] <= IDXW'(w);
    end else if (upd_i) begin
      rank_q <= rank_d;
    end
  end

  always_comb begin
    tail_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (rank_q[w] == IDXW'(WAYS - 1)) tail_o = IDXW'(w);
  end

  assign rank_o = rank_q;

  // Every rank position is held by exactly one way
  for (genvar r = 0; r < WAYS; r++) begin : g_perm
    logic [WAYS-1:0] holder;
    always_comb
      for (int w = 0; w < WAYS; w++) holder[w] = (rank_q[w] == IDXW'(r));
    // R3
    rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(holder) == 1);
  end

  // R5
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(rank_q));

endmodule

// File: rtl/svs_lfsr.sv
module svs_lfsr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  localparam logic [W-1:0] TAPS = W'(svs_pkg::lfsr_taps(W));

  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step_i) lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lfsr_q <= W'(1);
    else if (step_i) lfsr_q <= lfsr_d;
  end

  assign state_o = lfsr_q;

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(lfsr_q));

endmodule

// File: rtl/set_victim_sel.sv
module set_victim_sel #(
  parameter int WAYS   = 4,
  parameter int LFSR_W = 8,
  localparam int IDXW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            lookup_i,
  input  logic            hit_i,
  input  logic [IDXW-1:0] hit_way_i,
  input  logic            fill_i,
  output logic [IDXW-1:0] victim_o,
  output logic [WAYS-1:0] valid_o,
  output logic            full_o
);

  import svs_pkg::*;

  policy_e                   pol;
  logic                      lru_mode, hit_evt, lru_upd;
  logic [IDXW-1:0]           lru_way, lru_tail, fifo_tail, first_inv, rand_way;
  logic [WAYS-1:0][IDXW-1:0] lru_rank, fifo_rank;
  logic [LFSR_W-1:0]         lfsr;
  logic [WAYS-1:0]           valid_q, valid_d;

  assign pol      = policy_e'(mode_i);
  assign lru_mode = (pol == POL_LRU) || (pol == POL_RSVD);
  assign hit_evt  = lookup_i && hit_i && !fill_i;
  assign lru_upd  = fill_i || (hit_evt && lru_mode);
  assign lru_way  = fill_i ? victim_o : hit_way_i;

  svs_order #(.WAYS(WAYS), .IDXW(IDXW)) u_lru_order (
    .clk(clk), .rst_n(rst_n), .upd_i(lru_upd), .way_i(lru_way),
    .rank_o(lru_rank), .tail_o(lru_tail)
  );

  svs_order #(.WAYS(WAYS), .IDXW(IDXW)) u_fifo_order (
    .clk(clk), .rst_n(rst_n), .upd_i(fill_i), .way_i(victim_o),
    .rank_o(fifo_rank), .tail_o(fifo_tail)
  );

  svs_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_i(fill_i), .state_o(lfsr)
  );

  assign rand_way = IDXW'(lfsr % LFSR_W'(WAYS));

  // Lowest-numbered empty way
  always_comb begin
    first_inv = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_q[w]) first_inv = IDXW'(w);
  end

  always_comb begin
    if (!full_o) begin
      victim_o = first_inv;
    end else begin
      case (pol)
        POL_FIFO: victim_o = fifo_tail;
        POL_RAND: victim_o = rand_way;
        default:  victim_o = lru_tail;
      endcase
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (fill_i) valid_d[victim_o] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= '0;
    else if (fill_i) valid_q <= valid_d;
  end

  assign valid_o = valid_q;
  assign full_o  = &valid_q;

  // R3 (input assumption: hits only on resident ways, never with a fill)
  hit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_i && hit_i) |-> (valid_o[hit_way_i] && !fill_i));

  // R2
  free_way_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_o |-> !valid_o[victim_o]);

  // R2
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |=> valid_o[$past(victim_o)]);

  // R5
  fifo_hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && pol == POL_FIFO) |=> ($stable(victim_o) || $changed(mode_i)));

  // R8
  rand_hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && pol == POL_RAND) |=> ($stable(victim_o) || $changed(mode_i)));

  // R3
  lru_hit_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && lru_mode && full_o) |=> (victim_o != $past(hit_way_i)) || $changed(mode_i));

endmodule

// File: tb/set_victim_sel_tb.sv
module set_victim_sel_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       lk0, ht0, fl0, lk1, ht1, fl1;
  logic [1:0] hw0, hw1, vic0, vic1;
  logic [2:0] val0;
  logic [3:0] val1;
  logic       full0, full1;

  int nchk = 0;
  int nerr = 0;
  int tags [2][4];
  bit tv   [2][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  set_victim_sel #(.WAYS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .lookup_i(lk0), .hit_i(ht0),
    .hit_way_i(hw0), .fill_i(fl0), .victim_o(vic0), .valid_o(val0), .full_o(full0)
  );

  set_victim_sel #(.WAYS(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .lookup_i(lk1), .hit_i(ht1),
    .hit_way_i(hw1), .fill_i(fl1), .victim_o(vic1), .valid_o(val1), .full_o(full1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  task automatic drive(input int d, input bit lk, input bit ht, input int hw, input bit fl);
    if (d == 0) begin lk0 = lk; ht0 = ht; hw0 = 2'(hw); fl0 = fl; end
    else        begin lk1 = lk; ht1 = ht; hw1 = 2'(hw); fl1 = fl; end
  endtask

  function automatic int vic(input int d);
    return (d == 0) ? int'(vic0) : int'(vic1);
  endfunction

  task automatic do_reset(input logic [1:0] m);
    mode  = m;
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    for (int d = 0; d < 2; d++) for (int w = 0; w < 4; w++) tv[d][w] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_fill(input int d);
    drive(d, 0, 0, 0, 1);
    @(negedge clk);
    drive(d, 0, 0, 0, 0);
  endtask

  task automatic do_hit(input int d, input int w);
    drive(d, 1, 1, w, 0);
    @(negedge clk);
    drive(d, 0, 0, 0, 0);
  endtask

  // One access of a tag; returns hit flag and evicted tag (-1 if none)
  task automatic access(input int d, input int tag, output bit hit, output int ev);
    int nw = (d == 0) ? 3 : 4;
    int hw = -1;
    for (int w = 0; w < nw; w++) if (tv[d][w] && tags[d][w] == tag) hw = w;
    ev = -1;
    if (hw >= 0) begin
      hit = 1;
      do_hit(d, hw);
    end else begin
      int v;
      hit = 0;
      drive(d, 1, 0, 0, 0);
      @(negedge clk);
      drive(d, 0, 0, 0, 0);
      v = vic(d);
      if (tv[d][v]) ev = tags[d][v];
      do_fill(d);
      tags[d][v] = tag;
      tv[d][v]   = 1;
    end
  endtask

  task automatic run_trace(input int d, input int seq[], output int hits, output int evs[$]);
    bit h;
    int e;
    hits = 0;
    evs.delete();
    foreach (seq[i]) begin
      access(d, seq[i], h, e);
      if (h) hits++;
      if (e >= 0) evs.push_back(e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int tr_a[] = '{1, 2, 3, 1, 4, 2, 5, 1};
    int tr_b[] = '{1, 2, 3, 1, 4, 1};
    int tr_c[] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};
    int exp_ev[4] = '{2, 3, 1, 4};
    int hits;
    int evs[$];
    int cnt[4];
    int v;

    // R1 reset state
    do_reset(2'd0);
    check(val0 == 3'b000, "R1 valid", int'(val0), 0);
    check(full0 == 1'b0, "R1 full", int'(full0), 0);
    check(vic0 == 2'd0, "R1 victim", int'(vic0), 0);
    check(val1 == 4'b0000 && vic1 == 2'd0, "R1 dut4", int'(val1), 0);

    // R2 empty ways filled lowest first
    for (int k = 0; k < 3; k++) begin
      check(vic0 == 2'(k), "R2 victim", int'(vic0), k);
      do_fill(0);
      check(val0 == 3'((1 << (k + 1)) - 1), "R2 valid", int'(val0), (1 << (k + 1)) - 1);
    end
    check(full0 == 1'b1, "R2 full", int'(full0), 1);

    // R5 FIFO hit on oldest way leaves victim
    mode = 2'd1;
    @(negedge clk);
    check(vic0 == 2'd0, "R5 oldest", int'(vic0), 0);
    do_hit(0, 0);
    check(vic0 == 2'd0, "R5 hit no change", int'(vic0), 0);

    // R3 same hit in LRU mode promotes way 0
    mode = 2'd0;
    @(negedge clk);
    check(vic0 == 2'd0, "R3 tail before hit", int'(vic0), 0);
    do_hit(0, 0);
    check(vic0 == 2'd1, "R3 promote", int'(vic0), 1);
    drive(0, 1, 0, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0);
    check(vic0 == 2'd1, "R3 miss lookup no change", int'(vic0), 1);

    // R4 LRU traces
    do_reset(2'd0);
    run_trace(0, tr_a, hits, evs);
    check(hits == 1, "R4 lru trace A hits", hits, 1);
    check(evs.size() == 4, "R4 eviction count", evs.size(), 4);
    for (int i = 0; i < 4; i++)
      if (i < evs.size()) check(evs[i] == exp_ev[i], "R4 eviction order", evs[i], exp_ev[i]);
    do_reset(2'd0);
    run_trace(0, tr_b, hits, evs);
    check(hits == 2, "R4 lru trace B hits", hits, 2);

    // R6 FIFO traces
    do_reset(2'd1);
    run_trace(0, tr_a, hits, evs);
    check(hits == 2, "R6 fifo trace A hits", hits, 2);
    do_reset(2'd1);
    run_trace(0, tr_b, hits, evs);
    check(hits == 1, "R6 fifo trace B hits", hits, 1);

    // R7 growing ways raises FIFO misses
    do_reset(2'd1);
    run_trace(0, tr_c, hits, evs);
    check(12 - hits == 9, "R7 3-way misses", 12 - hits, 9);
    run_trace(1, tr_c, hits, evs);
    check(12 - hits == 10, "R7 4-way misses", 12 - hits, 10);

    // R8 random: range and hit immunity
    do_reset(2'd2);
    for (int k = 0; k < 20; k++) begin
      if (full0) check(vic0 < 2'd3, "R8 range", int'(vic0), 2);
      do_fill(0);
    end
    v = int'(vic0);
    do_hit(0, 1);
    check(int'(vic0) == v, "R8 hit no change", int'(vic0), v);

    // R9 distribution over one generator period
    for (int k = 0; k < 4; k++) do_fill(1);
    for (int w = 0; w < 4; w++) cnt[w] = 0;
    for (int k = 0; k < 255; k++) begin
      cnt[vic1]++;
      do_fill(1);
    end
    check(cnt[0] == 63, "R9 way 0", cnt[0], 63);
    for (int w = 1; w < 4; w++) check(cnt[w] == 64, "R9 way", cnt[w], 64);
    v = int'(vic1);
    do_hit(1, 3);
    check(int'(vic1) == v, "R8 dut4 hit no change", int'(vic1), v);

    summary();
  end

endmodule